// File: doc/BRIEF.md
# Polled Serial Port

This block connects a processor's I/O bus to a single asynchronous serial line. It has no interrupt output and no flow control. Software finds out whether a byte has arrived by polling a status port. A receive-ready flag there goes high once a full byte has been collected. Reading the data port returns that byte and lowers the flag.

The receiver runs in hardware. It uses one fixed frame: one start bit, eight data bits sent least significant bit first, no parity and one stop bit. Each bit lasts 192 system clocks, which gives 115200 baud from a 22.1184 MHz clock.

The transmit side has no shift register and no timing of its own. Every write to the data port copies bit 0 of the written byte onto the TX pin, and the pin keeps that level until the next such write. Software produces the whole outgoing waveform by timing its own writes.

Top module: `poll_uart_port`

## Requirements
- R1: After reset the TX pin is high (the idle mark level) and the receive-ready flag is low.
- R2: A write strobe at address 0xF9 sets the TX pin to bit 0 of the written byte one clock later. Bits 7:1 of that byte have no effect. The pin holds its level until the next write to 0xF9.
- R3: A write to any address other than 0xF9, including 0xF8, leaves the TX pin unchanged.
- R4: The receiver takes frames of one low start bit, eight data bits sent least significant bit first, and one high stop bit, at 192 clocks per bit. The last good byte is returned by a read of address 0xF9.
- R5: A read of status address 0xF8 returns the receive-ready flag in bit 0, with bits 7:1 reading as zero. The flag is still low at the start of the stop bit and is high by the end of the stop bit.
- R6: A read strobe at 0xF9 clears the receive-ready flag. If a new byte completes in the same clock, the flag stays set.
- R7: A frame whose stop bit samples low is discarded. The ready flag is not set. A correct frame that follows is received normally.
- R8: A start bit is accepted only if RX is still low at mid-bit, 96 clocks after the falling edge. A shorter low pulse produces no byte.
- R9: A read of any address other than 0xF8 or 0xF9 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the time base for the bit period |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 8 | I/O port address |
| io_wr | input | 1 | Write strobe, one clock per access |
| io_rd | input | 1 | Read strobe, one clock per access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational from address and strobe |
| rx_pin | input | 1 | Asynchronous serial receive line |
| tx_pin | output | 1 | Software-driven transmit line |

## Verification
A fault in the receiver's bit counter or its sampling point shows up as a wrong byte at 0xF9. It can also show as a ready flag that rises at the wrong point in the frame, and this is seen within one frame time (about 1900 clocks). To catch a flag that rises early, the status port is polled at the start of the stop bit. A stuck or misrouted ready flag shows on the very next status poll after a byte or a read. A wrong TX latch or a wrong address decode shows on tx_pin one clock after the write that exposes it.

// File: rtl/pu_pkg.sv
package pu_pkg;
    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_e;
endpackage

// File: rtl/pu_sync.sv
module pu_sync #(
    parameter int          STAGES    = 2,
    parameter logic        RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/pu_rx.sv
module pu_rx
    import pu_pkg::*;
#(
    parameter int CLKS_PER_BIT = 192,
    parameter int DATA_W       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_s,
    output logic              byte_valid,
    output logic [DATA_W-1:0] byte_out
);
    localparam int HALF = CLKS_PER_BIT / 2;
    localparam int CW   = $clog2(CLKS_PER_BIT);
    localparam int BW   = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    typedef struct packed {
        rx_state_e         st;
        logic [CW-1:0]     cnt;
        logic [BW-1:0]     idx;
        logic [DATA_W-1:0] shreg;
        logic              prev;
        logic              valid;
        logic [DATA_W-1:0] data;
    } rx_s_t;

    rx_s_t rx_d, rx_q;

    always_comb begin
        rx_d       = rx_q;
        rx_d.valid = 1'b0;
        rx_d.prev  = rx_s;
        case (rx_q.st)
            RX_IDLE: begin
                if (rx_q.prev && !rx_s) begin
                    rx_d.st  = RX_START;
                    rx_d.cnt = '0;
                end
            end
            RX_START: begin
                if (rx_q.cnt == CW'(HALF - 1)) begin
                    rx_d.cnt = '0;
                    rx_d.idx = '0;
                    rx_d.st  = rx_s ? RX_IDLE : RX_DATA;
                end else begin
                    rx_d.cnt = rx_q.cnt + 1'b1;
                end
            end
            RX_DATA: begin
                if (rx_q.cnt == CW'(CLKS_PER_BIT - 1)) begin
                    rx_d.cnt   = '0;
                    rx_d.shreg = {rx_s, rx_q.shreg[DATA_W-1:1]};
                    if (rx_q.idx == BW'(DATA_W - 1)) rx_d.st  = RX_STOP;
                    else                             rx_d.idx = rx_q.idx + 1'b1;
                end else begin
                    rx_d.cnt = rx_q.cnt + 1'b1;
                end
            end
            default: begin
                if (rx_q.cnt == CW'(CLKS_PER_BIT - 1)) begin
                    rx_d.cnt = '0;
                    rx_d.st  = RX_IDLE;
                    if (rx_s) begin
                        rx_d.valid = 1'b1;
                        rx_d.data  = rx_q.shreg;
                    end
                end else begin
                    rx_d.cnt = rx_q.cnt + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q       <= '0;
            rx_q.st    <= RX_IDLE;
            rx_q.prev  <= 1'b1;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign byte_valid = rx_q.valid;
    assign byte_out   = rx_q.data;

    // R4
    valid_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_q.valid |-> $past(rx_q.st) == RX_STOP);

    // R8
    start_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_q.st == RX_START) |-> (rx_q.cnt < CW'(HALF)));
endmodule

// File: rtl/pu_txpin.sv
module pu_txpin (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic bit_in,
    output logic tx
);
    logic tx_d, tx_q;

    always_comb begin
        tx_d = wr_en ? bit_in : tx_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tx_q <= 1'b1;
        else        tx_q <= tx_d;
    end

    assign tx = tx_q;

    // R2
    tx_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> tx_q == $past(bit_in));

    // R3
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(tx_q));
endmodule

// File: rtl/poll_uart_port.sv
module poll_uart_port #(
    parameter int          ADDR_W       = 8,
    parameter int          DATA_W       = 8,
    parameter int          CLKS_PER_BIT = 192,
    parameter int          SYNC_STAGES  = 2,
    parameter logic [7:0]  STAT_ADDR    = 8'hF8,
    parameter logic [7:0]  DATA_ADDR    = 8'hF9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] io_rdata,
    input  logic              rx_pin,
    output logic              tx_pin
);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_ADDR);

    logic              rx_s;
    logic              rx_valid;
    logic [DATA_W-1:0] rx_byte;
    logic              hit_stat, hit_data;
    logic              wr_data, rd_data;
    logic              ready_d, ready_q;

    assign hit_stat = (io_addr == A_STAT);
    assign hit_data = (io_addr == A_DATA);
    assign wr_data  = io_wr && hit_data;
    assign rd_data  = io_rd && hit_data;

    pu_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) i_sync (
        .clk(clk), .rst_n(rst_n), .din(rx_pin), .dout(rx_s)
    );

    pu_rx #(.CLKS_PER_BIT(CLKS_PER_BIT), .DATA_W(DATA_W)) i_rx (
        .clk(clk), .rst_n(rst_n), .rx_s(rx_s),
        .byte_valid(rx_valid), .byte_out(rx_byte)
    );

    pu_txpin i_tx (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_data),
        .bit_in(io_wdata[0]), .tx(tx_pin)
    );

    always_comb begin
        ready_d = ready_q;
        if (rd_data)  ready_d = 1'b0;
        if (rx_valid) ready_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ready_q <= 1'b0;
        else        ready_q <= ready_d;
    end

    always_comb begin
        io_rdata = '0;
        if (io_rd && hit_stat)      io_rdata = {{(DATA_W-1){1'b0}}, ready_q};
        else if (io_rd && hit_data) io_rdata = rx_byte;
    end

    // R6
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && !rx_valid) |=> !ready_q);

    // R6
    new_byte_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> ready_q);

    // R5
    ready_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_q) |-> $past(rx_valid));

    // R9
    idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_stat && !hit_data) |-> (io_rdata == '0));
endmodule

// File: tb/test_poll_uart_port.sv
module test_poll_uart_port;
    localparam int CLK_P = 10;
    localparam int BITC  = 192;
    localparam int WATCHDOG = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] io_addr = 8'h00;
    logic       io_wr = 1'b0;
    logic       io_rd = 1'b0;
    logic [7:0] io_wdata = 8'h00;
    logic [7:0] io_rdata;
    logic       rx_pin = 1'b1;
    logic       tx_pin;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    poll_uart_port i_poll_uart_port (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
        .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .rx_pin(rx_pin), .tx_pin(tx_pin)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1 d = io_rdata;
        @(negedge clk);
        io_rd = 1'b0; io_addr = 8'h00;
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0; io_addr = 8'h00;
    endtask

    task automatic send_frame(input logic [7:0] b, input logic stop_bit, input bit early);
        logic [7:0] s;
        @(negedge clk);
        rx_pin = 1'b0;
        repeat (BITC) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx_pin = b[i];
            repeat (BITC) @(negedge clk);
        end
        rx_pin = stop_bit;
        if (early) begin
            bus_rd(8'hF8, s);
            chk("R5 flag low at stop start", s, 8'h00);
            repeat (BITC - 2) @(negedge clk);
        end else begin
            repeat (BITC) @(negedge clk);
        end
        rx_pin = 1'b1;
        repeat (BITC/2) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] s;
        chk("R1 tx idle after reset", {7'b0, tx_pin}, 8'h01);
        bus_rd(8'hF8, s);
        chk("R1 ready low after reset", s, 8'h00);
    endtask

    task automatic t_tx();
        bus_wr(8'hF9, 8'hFE);
        chk("R2 tx from bit0=0", {7'b0, tx_pin}, 8'h00);
        bus_wr(8'hF9, 8'h55);
        chk("R2 tx from bit0=1, upper ignored", {7'b0, tx_pin}, 8'h01);
        bus_wr(8'hF9, 8'hAA);
        chk("R2 tx bit0=0 with upper set", {7'b0, tx_pin}, 8'h00);
        repeat (20) @(negedge clk);
        chk("R2 tx holds", {7'b0, tx_pin}, 8'h00);
        bus_wr(8'hF8, 8'hFF);
        chk("R3 write to status addr ignored", {7'b0, tx_pin}, 8'h00);
        bus_wr(8'h10, 8'h01);
        chk("R3 write to other addr ignored", {7'b0, tx_pin}, 8'h00);
        bus_wr(8'hF9, 8'h01);
        chk("R2 tx back high", {7'b0, tx_pin}, 8'h01);
    endtask

    task automatic t_rx_bytes();
        logic [7:0] pat [4] = '{8'hA5, 8'h00, 8'hFF, 8'h3C};
        logic [7:0] s, d;
        foreach (pat[k]) begin
            send_frame(pat[k], 1'b1, 1'b1);
            bus_rd(8'hF8, s);
            chk("R5 ready set after frame", s, 8'h01);
            bus_rd(8'hF9, d);
            chk("R4 received byte", d, pat[k]);
            bus_rd(8'hF8, s);
            chk("R6 read clears ready", s, 8'h00);
        end
    endtask

    task automatic t_framing();
        logic [7:0] s, d;
        send_frame(8'h5A, 1'b0, 1'b0);
        repeat (BITC) @(negedge clk);
        bus_rd(8'hF8, s);
        chk("R7 bad stop leaves ready low", s, 8'h00);
        bus_rd(8'hF9, d);
        chk("R7 bad frame not stored", d, 8'h3C);
        send_frame(8'hC3, 1'b1, 1'b0);
        bus_rd(8'hF8, s);
        chk("R7 good frame after bad one", s, 8'h01);
        bus_rd(8'hF9, d);
        chk("R7 byte after bad frame", d, 8'hC3);
    endtask

    task automatic t_glitch();
        logic [7:0] s;
        @(negedge clk);
        rx_pin = 1'b0;
        repeat (40) @(negedge clk);
        rx_pin = 1'b1;
        repeat (12 * BITC) @(negedge clk);
        bus_rd(8'hF8, s);
        chk("R8 short low pulse ignored", s, 8'h00);
    endtask

    task automatic t_decode();
        logic [7:0] d;
        send_frame(8'h81, 1'b1, 1'b0);
        bus_rd(8'h00, d);
        chk("R9 other address reads zero", d, 8'h00);
        bus_rd(8'hFA, d);
        chk("R9 neighbour address reads zero", d, 8'h00);
        bus_rd(8'hF8, d);
        chk("R5 status upper bits zero", d, 8'h01);
        bus_rd(8'hF9, d);
        chk("R4 byte 81", d, 8'h81);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_tx();
        t_rx_bytes();
        t_framing();
        t_glitch();
        t_decode();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(negedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule